// File: doc/BRIEF.md
# Data Access Breakpoint Comparator

This block watches the data bus cycles of a processor subsystem and flags each cycle that meets a programmed breakpoint condition. Each channel holds its own condition: a break address, an optional operand-size restriction, an optional read or write restriction and an optional data value with a per-bit mask. The parameter `NCH` sets the number of channels (two by default). The channels are identical and independent. A channel also selects which bus it watches. On the CPU execution side, a request waits for an instruction boundary. On the shared system side, any bus master can trigger it and the request follows the matching cycle directly.

The address comparison adapts to the width of the access. A longword access ignores the two lowest address bits, a word access ignores bit 0, and a byte access compares every bit. A single programmed address therefore catches any access that covers it. Data comparison takes the byte lane or halfword addressed by the cycle. For a byte condition, the reference byte is programmed into both of the two low byte lanes of the data and mask values.

The monitored bus is an observe-only stream. `mon_valid` qualifies one cycle and the block has no ready signal, so it never stalls or back-pressures the bus. Every valid cycle is evaluated in the clock in which it appears. Configuration inputs are plain levels and are expected to be stable while cycles are being watched.

Top module: `dab_comparator`

## Requirements
- R1: The address compare excludes address bits [1:0] for a longword access (`mon_size`=2), bit [0] for a word access (`mon_size`=1), and no bits for a byte access (`mon_size`=0). With break address 0x1003, a longword at 0x1000, a word at 0x1002 and a byte at 0x1003 all match. A byte at 0x1002, a word at 0x1000 and a longword at 0x1004 do not.
- R2: The operand-size select `cfg_opsz` is coded 0 for any size, 1 for byte only, 2 for word only and 3 for longword only. A cycle whose size differs from a non-zero selection never matches.
- R3: With `cfg_den`=1, a match needs both the address condition and the data condition. A mask bit of 1 removes that data bit from the compare. A byte access compares data lane `addr[1:0]` (lane k is bits 8k+7:8k) against reference bits [7:0]. A word access compares half `addr[1]` (0 = bits 15:0, 1 = bits 31:16) against reference bits [15:0]. For byte and word, reference and mask bits [31:16] are ignored. `cfg_den`=1 with `cfg_opsz`=0 never matches.
- R4: The read/write select `cfg_rw` is coded 1 to match reads only (`mon_wr`=0), 2 to match writes only (`mon_wr`=1), and 0 or 3 to match either.
- R5: `match_flag` rises in the cycle after a matching cycle and stays set until `flag_clr` is asserted. A match in the same cycle as `flag_clr` leaves the flag set.
- R6: A channel with `cfg_sys`=1 considers only cycles with `mon_sys`=1. Its `brk_req` is a one-cycle pulse in the cycle after the matching cycle.
- R7: A channel with `cfg_sys`=0 considers only cycles with `mon_sys`=0. Its `brk_req` pulses in the cycle after the first `instr_done` strobe that comes after the matching cycle. A strobe in the matching cycle itself is not counted.
- R8: A channel with `cfg_sys`=0 and `cfg_den`=1 pulses `brk_req` in the cycle after the second `instr_done` strobe that comes after the matching cycle.
- R9: While `ch_en` is low, a channel ignores every cycle, its flag does not set, and a request that was waiting for an instruction boundary is dropped.
- R10: Channels evaluate independently. A bus cycle that meets the conditions of both channels sets both flags in the same cycle.
- R11: During and after reset, all flags and requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Per-channel enable |
| cfg_addr | input | NCH x AW | Break address per channel |
| cfg_data | input | NCH x 32 | Reference data per channel |
| cfg_mask | input | NCH x 32 | Data mask per channel, 1 = bit excluded |
| cfg_opsz | input | NCH x 2 | Operand size select |
| cfg_rw | input | NCH x 2 | Read/write select |
| cfg_den | input | NCH | Data condition enable |
| cfg_sys | input | NCH | Bus select: 1 = system bus, 0 = CPU execution bus |
| flag_clr | input | NCH | Clears the match flag of the channel |
| mon_valid | input | 1 | Monitored cycle valid |
| mon_sys | input | 1 | Cycle is on the system bus (1) or the CPU bus (0) |
| mon_addr | input | AW | Cycle address |
| mon_data | input | 32 | Cycle data, lane aligned |
| mon_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| mon_wr | input | 1 | 1 = write, 0 = read |
| instr_done | input | 1 | Instruction completion strobe |
| match_flag | output | NCH | Sticky match flag per channel |
| brk_req | output | NCH | Break request pulse per channel |

## Verification
A matching cycle sets `match_flag` exactly one clock later. A system-bus request appears one clock after the matching cycle. A CPU-bus request appears one clock after the first `instr_done` strobe, or after the second strobe when a data condition is set. The bench drives each cycle on a falling edge and releases it on the next falling edge. It samples the flag and the system-bus request at that second falling edge, which is the first point at which both are due. For CPU-bus cases, it first confirms that `brk_req` stays low before any strobe and after a non-final strobe. It then pulses `instr_done` for one cycle and samples `brk_req` on the falling edge that follows.

// File: rtl/dab_pkg.sv
package dab_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_LONG = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    OPS_ANY  = 2'd0,
    OPS_BYTE = 2'd1,
    OPS_WORD = 2'd2,
    OPS_LONG = 2'd3
  } op_sel_e;

  // size restriction: any, or the selection must equal the bus size
  function automatic logic size_ok(input logic [1:0] sel, input logic [1:0] sz);
    case (sel)
      OPS_BYTE: size_ok = (sz == ACC_BYTE);
      OPS_WORD: size_ok = (sz == ACC_WORD);
      OPS_LONG: size_ok = (sz == ACC_LONG);
      default:  size_ok = 1'b1;
    endcase
  endfunction

  // read/write restriction: 1 reads, 2 writes, else both
  function automatic logic dir_ok(input logic [1:0] sel, input logic wr);
    case (sel)
      2'd1:    dir_ok = ~wr;
      2'd2:    dir_ok = wr;
      default: dir_ok = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dab_addr_match.sv
module dab_addr_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  output logic          hit
);
  import dab_pkg::*;

  logic [AW-1:0] care;

  // low bits dropped from the compare grow with the access width
  always_comb begin
    care = '1;
    case (bus_size)
      ACC_BYTE: care = '1;
      ACC_WORD: care[0] = 1'b0;
      default:  care[1:0] = 2'b00;
    endcase
  end

  assign hit = (((ref_addr ^ bus_addr) & care) == '0);
endmodule

// File: rtl/dab_data_match.sv
module dab_data_match
  import dab_pkg::*;
(
  input  logic [DATA_W-1:0] ref_data,
  input  logic [DATA_W-1:0] ref_mask,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        addr_lo,
  input  logic [1:0]        opsz,
  output logic              hit
);
  logic [7:0]  lane [LANES];
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = bus_data[8*g +: 8];
  end

  assign byte_v = lane[addr_lo];
  assign half_v = addr_lo[1] ? bus_data[31:16] : bus_data[15:0];

  always_comb begin
    case (opsz)
      OPS_BYTE: hit = (((byte_v ^ ref_data[7:0])  & ~ref_mask[7:0])  == '0);
      OPS_WORD: hit = (((half_v ^ ref_data[15:0]) & ~ref_mask[15:0]) == '0);
      OPS_LONG: hit = (((bus_data ^ ref_data)     & ~ref_mask)       == '0);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dab_channel.sv
module dab_channel
  import dab_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [AW-1:0]     c_addr,
  input  logic [DATA_W-1:0] c_data,
  input  logic [DATA_W-1:0] c_mask,
  input  logic [1:0]        c_opsz,
  input  logic [1:0]        c_rw,
  input  logic              c_den,
  input  logic              c_sys,
  input  logic              clr,
  input  logic              m_valid,
  input  logic              m_sys,
  input  logic [AW-1:0]     m_addr,
  input  logic [DATA_W-1:0] m_data,
  input  logic [1:0]        m_size,
  input  logic              m_wr,
  input  logic              idone,
  output logic              flag,
  output logic              req
);
  logic a_hit, d_hit, hit;
  logic [1:0] wait_cnt;

  dab_addr_match #(.AW(AW)) u_amatch (
    .ref_addr (c_addr),
    .bus_addr (m_addr),
    .bus_size (m_size),
    .hit      (a_hit)
  );

  dab_data_match u_dmatch (
    .ref_data (c_data),
    .ref_mask (c_mask),
    .bus_data (m_data),
    .addr_lo  (m_addr[1:0]),
    .opsz     (c_opsz),
    .hit      (d_hit)
  );

  assign hit = en & m_valid & (m_sys == c_sys) & dir_ok(c_rw, m_wr)
             & size_ok(c_opsz, m_size) & a_hit & (~c_den | d_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      req      <= 1'b0;
      wait_cnt <= 2'd0;
    end else begin
      flag <= hit | (flag & ~clr);
      if (!en) begin
        req      <= 1'b0;
        wait_cnt <= 2'd0;
      end else if (hit) begin
        req      <= c_sys;
        wait_cnt <= c_sys ? 2'd0 : (c_den ? 2'd2 : 2'd1);
      end else begin
        req <= 1'b0;
        if (idone && wait_cnt != 2'd0) begin
          wait_cnt <= wait_cnt - 2'd1;
          req      <= (wait_cnt == 2'd1);
        end
      end
    end
  end
endmodule

// File: rtl/dab_comparator.sv
module dab_comparator
  import dab_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0]                ch_en,
  input  logic [NCH-1:0][AW-1:0]        cfg_addr,
  input  logic [NCH-1:0][DATA_W-1:0]    cfg_data,
  input  logic [NCH-1:0][DATA_W-1:0]    cfg_mask,
  input  logic [NCH-1:0][1:0]           cfg_opsz,
  input  logic [NCH-1:0][1:0]           cfg_rw,
  input  logic [NCH-1:0]                cfg_den,
  input  logic [NCH-1:0]                cfg_sys,
  input  logic [NCH-1:0]                flag_clr,
  input  logic                          mon_valid,
  input  logic                          mon_sys,
  input  logic [AW-1:0]                 mon_addr,
  input  logic [DATA_W-1:0]             mon_data,
  input  logic [1:0]                    mon_size,
  input  logic                          mon_wr,
  input  logic                          instr_done,
  output logic [NCH-1:0]                match_flag,
  output logic [NCH-1:0]                brk_req
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dab_channel #(.AW(AW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ch_en[c]),
      .c_addr  (cfg_addr[c]),
      .c_data  (cfg_data[c]),
      .c_mask  (cfg_mask[c]),
      .c_opsz  (cfg_opsz[c]),
      .c_rw    (cfg_rw[c]),
      .c_den   (cfg_den[c]),
      .c_sys   (cfg_sys[c]),
      .clr     (flag_clr[c]),
      .m_valid (mon_valid),
      .m_sys   (mon_sys),
      .m_addr  (mon_addr),
      .m_data  (mon_data),
      .m_size  (mon_size),
      .m_wr    (mon_wr),
      .idone   (instr_done),
      .flag    (match_flag[c]),
      .req     (brk_req[c])
    );
  end
endmodule

// File: rtl/dab_comparator_chk.sv
module dab_comparator_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] cfg_sys,
  input logic [NCH-1:0] flag_clr,
  input logic           mon_valid,
  input logic           mon_sys,
  input logic           instr_done,
  input logic [NCH-1:0] match_flag,
  input logic [NCH-1:0] brk_req
);
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r11: assert (match_flag == '0 && brk_req == '0);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_flag[c] && !flag_clr[c] |=> match_flag[c]);

    p_flag_drop_needs_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(match_flag[c]) |-> $past(flag_clr[c]));

    p_sys_req_follows_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req[c] && cfg_sys[c] |-> $past(mon_valid && mon_sys) && match_flag[c]);

    p_cpu_req_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req[c] && !cfg_sys[c] |-> $past(instr_done));

    p_disabled_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> !brk_req[c]);
  end
endmodule

bind dab_comparator dab_comparator_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_en      (ch_en),
  .cfg_sys    (cfg_sys),
  .flag_clr   (flag_clr),
  .mon_valid  (mon_valid),
  .mon_sys    (mon_sys),
  .instr_done (instr_done),
  .match_flag (match_flag),
  .brk_req    (brk_req)
);

// File: tb/dab_comparator_bench.sv
`timescale 1ns/1ps
module dab_comparator_bench;
  localparam int NCH = 2;
  localparam int AW  = 32;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NCH-1:0]         ch_en = '1;
  logic [NCH-1:0][AW-1:0] cfg_addr = '0;
  logic [NCH-1:0][31:0]   cfg_data = '0;
  logic [NCH-1:0][31:0]   cfg_mask = '0;
  logic [NCH-1:0][1:0]    cfg_opsz = '0;
  logic [NCH-1:0][1:0]    cfg_rw = '0;
  logic [NCH-1:0]         cfg_den = '0;
  logic [NCH-1:0]         cfg_sys = '1;
  logic [NCH-1:0]         flag_clr = '0;
  logic                   mon_valid = 1'b0;
  logic                   mon_sys = 1'b0;
  logic [AW-1:0]          mon_addr = '0;
  logic [31:0]            mon_data = '0;
  logic [1:0]             mon_size = '0;
  logic                   mon_wr = 1'b0;
  logic                   instr_done = 1'b0;
  logic [NCH-1:0]         match_flag;
  logic [NCH-1:0]         brk_req;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  dab_comparator #(.NCH(NCH), .AW(AW)) u_dab_comparator (.*);

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  sz;
    logic        wr;
    logic        sys;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 32'h0, 2'd2, 1'b0, 1'b1, 2'b01},  // R1 long covers 0x1003
    '{32'h0000_1002, 32'h0, 2'd1, 1'b1, 1'b1, 2'b01},  // R1 word covers 0x1003
    '{32'h0000_1003, 32'h0, 2'd0, 1'b0, 1'b1, 2'b01},  // R1 byte exact
    '{32'h0000_1002, 32'h0, 2'd0, 1'b0, 1'b1, 2'b00},  // R1 byte neighbour
    '{32'h0000_1000, 32'h0, 2'd1, 1'b0, 1'b1, 2'b00},  // R1 other half
    '{32'h0000_1004, 32'h0, 2'd2, 1'b0, 1'b1, 2'b00},  // R1 next long
    '{32'h0000_1003, 32'h0, 2'd0, 1'b0, 1'b0, 2'b00},  // R6 wrong bus
    '{32'h0000_2002, 32'hA5C3_0000, 2'd1, 1'b1, 1'b1, 2'b10},  // R3 upper half
    '{32'h0000_2002, 32'hAAC3_0000, 2'd1, 1'b1, 1'b1, 2'b10},  // R3 masked nibble
    '{32'h0000_2002, 32'hA5C2_0000, 2'd1, 1'b1, 1'b1, 2'b00},  // R3 data miss
    '{32'h0000_2002, 32'hA5C3_0000, 2'd1, 1'b0, 1'b1, 2'b00},  // R4 read refused
    '{32'h0000_2003, 32'hA5C3_0000, 2'd1, 1'b1, 1'b1, 2'b10},  // R1 word ignores bit0
    '{32'h0000_2000, 32'h0000_A5C3, 2'd1, 1'b1, 1'b1, 2'b00},  // R1 addr bit1 differs
    '{32'h0000_2002, 32'hA5C3_0000, 2'd2, 1'b1, 1'b1, 2'b00},  // R2 size mismatch
    '{32'h0000_1001, 32'h0, 2'd2, 1'b1, 1'b1, 2'b01}   // R1 long ignores [1:0]
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one bus cycle for one clock; return on the falling edge after it
  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                     input logic wr, input logic sys, input logic idn);
    @(negedge clk);
    mon_valid = 1'b1; mon_addr = a; mon_data = d; mon_size = sz;
    mon_wr = wr; mon_sys = sys; instr_done = idn;
    @(negedge clk);
    mon_valid = 1'b0; instr_done = 1'b0;
  endtask

  task automatic strobe_done();
    @(negedge clk);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 flags in reset", {30'd0, match_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 flags after reset", {30'd0, match_flag}, 32'd0);
    check("R11 req after reset", {30'd0, brk_req}, 32'd0);

    // table configuration
    cfg_addr[0] = 32'h0000_1003; cfg_opsz[0] = 2'd0; cfg_rw[0] = 2'd0; cfg_den[0] = 1'b0;
    cfg_addr[1] = 32'h0000_2002; cfg_data[1] = 32'hFFFF_A5C3; cfg_mask[1] = 32'h0000_0F00;
    cfg_opsz[1] = 2'd2; cfg_rw[1] = 2'd2; cfg_den[1] = 1'b1;
    cfg_sys = '1;

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].a, VECS[i].d, VECS[i].sz, VECS[i].wr, VECS[i].sys, 1'b0);
      check($sformatf("R1/R3/R6 vec %0d flag", i), {30'd0, match_flag}, {30'd0, VECS[i].exp});
      check($sformatf("R6 vec %0d req", i), {30'd0, brk_req}, {30'd0, VECS[i].exp});
      clear_all();
    end

    // R5 sticky flag, request is a single pulse
    bus(32'h0000_1003, 32'h0, 2'd0, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 flag held", {31'd0, match_flag[0]}, 32'd1);
    check("R6 req one pulse", {31'd0, brk_req[0]}, 32'd0);
    clear_all();
    check("R5 flag cleared", {31'd0, match_flag[0]}, 32'd0);

    // R5 match wins over simultaneous clear
    @(negedge clk);
    flag_clr = 2'b01;
    mon_valid = 1'b1; mon_addr = 32'h0000_1003; mon_size = 2'd0; mon_sys = 1'b1; mon_wr = 1'b0;
    @(negedge clk);
    flag_clr = '0; mon_valid = 1'b0;
    check("R5 set beats clear", {31'd0, match_flag[0]}, 32'd1);
    clear_all();

    // R10 both channels in one cycle
    cfg_addr[1] = 32'h0000_1003; cfg_den[1] = 1'b0; cfg_opsz[1] = 2'd0; cfg_rw[1] = 2'd0;
    bus(32'h0000_1000, 32'h0, 2'd2, 1'b1, 1'b1, 1'b0);
    check("R10 both flags", {30'd0, match_flag}, 32'd3);
    clear_all();

    // R9 disabled channel ignores
    ch_en = 2'b10;
    bus(32'h0000_1003, 32'h0, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R9 disabled flag", {30'd0, match_flag}, 32'd2);
    check("R9 disabled req", {30'd0, brk_req}, 32'd2);
    ch_en = 2'b11;
    clear_all();

    // R3 byte data condition on lane 1, upper reference bits ignored
    cfg_addr[1] = 32'h0000_3001; cfg_opsz[1] = 2'd1; cfg_den[1] = 1'b1;
    cfg_data[1] = 32'hDEAD_3C3C; cfg_mask[1] = 32'hFFFF_0000;
    bus(32'h0000_3001, 32'h0000_3C00, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R3 byte lane hit", {31'd0, match_flag[1]}, 32'd1);
    clear_all();
    bus(32'h0000_3001, 32'h0000_003C, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R3 byte wrong lane", {31'd0, match_flag[1]}, 32'd0);
    clear_all();

    // R3 data condition with size any never matches
    cfg_opsz[1] = 2'd0;
    bus(32'h0000_3001, 32'h0000_3C00, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R3 den with any size", {31'd0, match_flag[1]}, 32'd0);
    clear_all();

    // R7 CPU bus: wait for instruction boundary
    cfg_sys = 2'b00;
    bus(32'h0000_1003, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R7 flag on cpu bus", {31'd0, match_flag[0]}, 32'd1);
    check("R7 no req before boundary", {31'd0, brk_req[0]}, 32'd0);
    repeat (2) @(negedge clk);
    check("R7 still waiting", {31'd0, brk_req[0]}, 32'd0);
    strobe_done();
    check("R7 req after boundary", {31'd0, brk_req[0]}, 32'd1);
    @(negedge clk);
    check("R7 req pulse ends", {31'd0, brk_req[0]}, 32'd0);
    clear_all();

    // R8 CPU bus with data condition waits two boundaries
    cfg_addr[1] = 32'h0000_4000; cfg_opsz[1] = 2'd3; cfg_den[1] = 1'b1;
    cfg_data[1] = 32'h1234_5678; cfg_mask[1] = 32'h0;
    bus(32'h0000_4000, 32'h1234_5678, 2'd2, 1'b1, 1'b0, 1'b0);
    check("R8 flag", {31'd0, match_flag[1]}, 32'd1);
    strobe_done();
    check("R8 no req after first", {31'd0, brk_req[1]}, 32'd0);
    strobe_done();
    check("R8 req after second", {31'd0, brk_req[1]}, 32'd1);
    clear_all();

    // R9 disabling drops a waiting request
    bus(32'h0000_1003, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    ch_en = 2'b10;
    @(negedge clk);
    ch_en = 2'b11;
    strobe_done();
    check("R9 pending dropped", {31'd0, brk_req[0]}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule